// File: doc/BRIEF.md
# Receive Word-Clock Pulse Shaper

This block sits on the receive side of a narrow serial link. It takes a stream of serial bits, one per bit-rate enable, and cuts it into slots of 14 bit times. Each slot begins with a 2-bit marker and ends with a 12-bit payload. A data slot puts its payload on the parallel word output. In the same clock cycle it starts a word-clock pulse whose active phase lasts a programmable number of bit times. An idle slot leaves both the word and the word clock alone. As a result the word clock pulses once per transmitted word, and its average rate matches the sender's strobe rate.

A two-bit pulse-width select chooses how long the active phase lasts and which edge the reader uses. A direction input turns the receive path off while the parallel word holds its last value. A two-bit mode select of all zeros powers the block down. In power-down the outputs are tri-stated through separate enables, and all internal state is cleared.

Top module: `wck_deser_top`

## Requirements
- R1: A slot is 14 bit enables. The marker comes first, then 12 payload bits, most significant first. After marker `10`, `word_out` takes the payload on the clock edge of the 14th bit enable and not earlier. Cycles with `bit_en` low advance nothing.
- R2: For select codes `00`, `10` and `11`, `wclk_out` falls on the same clock edge on which `word_out` changes.
- R3: The active phase lasts 7 bit enables for select `00`, 13 for `10` and 17 for `11`. It is counted from the load edge. The level is released on the edge of the last of these enables.
- R4: Select `01` inverts `wclk_out`. The output rises together with the data change, stays high for 7 bit enables, then goes low.
- R5: A slot with marker `01` (idle) changes neither `word_out` nor `wclk_out`.
- R6: A slot with marker `00` or `11` is discarded. The framer then re-tests the marker on every following bit enable until it finds a valid one.
- R7: If a data slot completes while the active phase is still running, `wclk_out` is released on that edge with the old word still shown. On the next clock edge the new word appears and a fresh active phase begins.
- R8: `mode_sel` = `00` drives `word_oe` and `wclk_oe` low and clears all state. After leaving power-down, `word_out` reads 0 and `wclk_out` sits at its released level.
- R9: With `rx_sel` low, incoming slots are ignored, `word_out` keeps its last value and `wclk_out` is released. When `rx_sel` returns high, the next slot is decoded normally.
- R10: After reset, with a nonzero mode, `word_out` is 0, `wclk_out` is high for select `00`, and both output enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse per serial bit time |
| ser_in | input | 1 | Serial bit, sampled when bit_en is high |
| rx_sel | input | 1 | 1 = receive, 0 = transmit direction (receive path idle) |
| mode_sel | input | 2 | 00 = power-down, any other value = active |
| pw_sel | input | 2 | Active-phase length and polarity select |
| word_out | output | 12 | Recovered parallel word |
| word_oe | output | 1 | Output enable for word_out |
| wclk_out | output | 1 | Word clock |
| wclk_oe | output | 1 | Output enable for wclk_out |

## Verification
A new word can complete while the 17-bit active phase of the previous word is still running. In that case the release of the word clock and the load of the new word compete for the same edge. The bench provokes this with two back-to-back data slots under select `11`. On the 14th bit edge it expects the clock released with the old word. One cycle later it expects the new word with a falling clock. Invalid-marker slots are also sent to confirm that they are dropped and that the framer locks onto the following data slot.

// File: rtl/wck_pkg.sv
package wck_pkg;

    localparam int MARK_W = 2;

    localparam logic [MARK_W-1:0] MARK_DATA = 2'b10;
    localparam logic [MARK_W-1:0] MARK_IDLE = 2'b01;

    localparam logic [1:0] MODE_OFF = 2'b00;

    typedef enum logic [1:0] {
        PW_SHORT    = 2'b00,
        PW_HALF_INV = 2'b01,
        PW_MID      = 2'b10,
        PW_LONG     = 2'b11
    } pw_sel_e;

endpackage

// File: rtl/wck_slot_framer.sv
module wck_slot_framer
    import wck_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_en,
    input  logic              ser_in,
    output logic              word_stb,
    output logic [WORD_W-1:0] word_data
);

    localparam int SLOT_W = WORD_W + MARK_W;
    localparam int CNT_W  = $clog2(SLOT_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_W - 1);

    typedef struct packed {
        logic [SLOT_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } frm_t;

    frm_t frm_d, frm_q;
    logic [SLOT_W-1:0] shifted;
    logic [MARK_W-1:0] marker;

    always_comb begin
        frm_d     = frm_q;
        word_stb  = 1'b0;
        shifted   = {frm_q.sr[SLOT_W-2:0], ser_in};
        marker    = shifted[SLOT_W-1 -: MARK_W];
        word_data = shifted[WORD_W-1:0];
        if (clear) begin
            frm_d = '0;
        end else if (bit_en) begin
            frm_d.sr = shifted;
            if (frm_q.cnt == LAST) begin
                // a bad marker leaves the count at LAST: test again next bit
                if (marker == MARK_DATA || marker == MARK_IDLE) begin
                    frm_d.cnt = '0;
                end
                word_stb = (marker == MARK_DATA);
            end else begin
                frm_d.cnt = frm_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

endmodule

// File: rtl/wck_pulse_gen.sv
module wck_pulse_gen
    import wck_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int LOW_SHORT = 7,
    parameter int LOW_MID   = 13,
    parameter int LOW_LONG  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_all,
    input  logic              hold,
    input  logic              bit_en,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] word_data,
    input  pw_sel_e           pw,
    output logic [WORD_W-1:0] word,
    output logic              wclk
);

    localparam int LCNT_W = $clog2(LOW_LONG);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] pend_word;
        logic [LCNT_W-1:0] lcnt;
        logic              act;
        logic              pend;
    } pg_t;

    pg_t pg_d, pg_q;
    logic [LCNT_W-1:0] reload;

    always_comb begin
        unique case (pw)
            PW_MID:  reload = LCNT_W'(LOW_MID - 1);
            PW_LONG: reload = LCNT_W'(LOW_LONG - 1);
            default: reload = LCNT_W'(LOW_SHORT - 1);
        endcase
    end

    always_comb begin
        pg_d = pg_q;
        if (clear_all) begin
            pg_d = '0;
        end else if (hold) begin
            pg_d.act  = 1'b0;
            pg_d.pend = 1'b0;
            pg_d.lcnt = '0;
        end else if (pg_q.pend) begin
            pg_d.word = pg_q.pend_word;
            pg_d.act  = 1'b1;
            pg_d.lcnt = reload;
            pg_d.pend = 1'b0;
        end else if (word_stb) begin
            if (pg_q.act) begin
                // release now, start the new pulse on the next edge
                pg_d.act       = 1'b0;
                pg_d.pend      = 1'b1;
                pg_d.pend_word = word_data;
            end else begin
                pg_d.word = word_data;
                pg_d.act  = 1'b1;
                pg_d.lcnt = reload;
            end
        end else if (bit_en && pg_q.act) begin
            if (pg_q.lcnt == '0) pg_d.act  = 1'b0;
            else                 pg_d.lcnt = pg_q.lcnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign word = pg_q.word;
    assign wclk = ~pg_q.act ^ (pw == PW_HALF_INV);

endmodule

// File: rtl/wck_deser_top.sv
module wck_deser_top
    import wck_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int LOW_SHORT = 7,
    parameter int LOW_MID   = 13,
    parameter int LOW_LONG  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              ser_in,
    input  logic              rx_sel,
    input  logic [1:0]        mode_sel,
    input  logic [1:0]        pw_sel,
    output logic [WORD_W-1:0] word_out,
    output logic              word_oe,
    output logic              wclk_out,
    output logic              wclk_oe
);

    logic              powered_off;
    logic              stb;
    logic [WORD_W-1:0] data;

    assign powered_off = (mode_sel == MODE_OFF);

    wck_slot_framer #(.WORD_W(WORD_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (powered_off | ~rx_sel),
        .bit_en    (bit_en),
        .ser_in    (ser_in),
        .word_stb  (stb),
        .word_data (data)
    );

    wck_pulse_gen #(
        .WORD_W    (WORD_W),
        .LOW_SHORT (LOW_SHORT),
        .LOW_MID   (LOW_MID),
        .LOW_LONG  (LOW_LONG)
    ) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (powered_off),
        .hold      (~rx_sel),
        .bit_en    (bit_en),
        .word_stb  (stb),
        .word_data (data),
        .pw        (pw_sel_e'(pw_sel)),
        .word      (word_out),
        .wclk      (wclk_out)
    );

    assign word_oe = ~powered_off;
    assign wclk_oe = ~powered_off;

endmodule

// File: rtl/wck_deser_checker.sv
module wck_deser_checker #(
    parameter int WORD_W   = 12,
    parameter int LOW_LONG = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_en,
    input logic              rx_sel,
    input logic [1:0]        mode_sel,
    input logic [1:0]        pw_sel,
    input logic [WORD_W-1:0] word_out,
    input logic              wclk_out,
    input logic              word_oe
);

    logic [5:0] run_q;
    logic       released;

    assign released = wclk_out ^ (pw_sel == 2'b01);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           run_q <= '0;
        else if (!word_oe || !rx_sel || released) run_q <= '0;
        else if (bit_en)                      run_q <= run_q + 1'b1;
    end

    // R1: the word only moves one or two edges after a bit enable
    a_r1_word_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(word_out) && mode_sel != 2'b00 && $past(mode_sel) != 2'b00)
        |-> ($past(bit_en) || $past(bit_en, 2)));

    // R2: falling word clock accompanies every data change
    a_r2_fall_with_data: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(word_out) && pw_sel != 2'b01 && $stable(pw_sel)
         && mode_sel != 2'b00 && $past(mode_sel) != 2'b00)
        |-> $fell(wclk_out));

    // R3: active phase never spans more than the longest setting
    a_r3_low_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= 6'(LOW_LONG));

    // R8: power-down clears the held word
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00) |=> (word_out == '0));

    // R9: transmit direction keeps the word
    a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_sel && !$past(rx_sel) && mode_sel != 2'b00 && $past(mode_sel) != 2'b00)
        |-> $stable(word_out));

endmodule

bind wck_deser_top wck_deser_checker #(.WORD_W(WORD_W), .LOW_LONG(LOW_LONG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .rx_sel   (rx_sel),
    .mode_sel (mode_sel),
    .pw_sel   (pw_sel),
    .word_out (word_out),
    .wclk_out (wclk_out),
    .word_oe  (word_oe)
);

// File: tb/wck_deser_top_bench.sv
`timescale 1ns/1ps
module wck_deser_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        ser_in = 1'b0;
    logic        rx_sel = 1'b1;
    logic [1:0]  mode_sel = 2'b11;
    logic [1:0]  pw_sel = 2'b00;
    logic [11:0] word_out;
    logic        word_oe;
    logic        wclk_out;
    logic        wclk_oe;

    int n_chk = 0;
    int n_fail = 0;
    int since_load = 0;
    int meas = -1;
    bit tracking = 1'b0;
    bit inv_b = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wck_deser_top u_wck_deser_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .ser_in   (ser_in),
        .rx_sel   (rx_sel),
        .mode_sel (mode_sel),
        .pw_sel   (pw_sel),
        .word_out (word_out),
        .word_oe  (word_oe),
        .wclk_out (wclk_out),
        .wclk_oe  (wclk_oe)
    );

    // {pw_sel, payload, expected active length in bit enables}
    localparam logic [18:0] VEC [6] = '{
        {2'b00, 12'hA5C, 5'd7},
        {2'b10, 12'h3F1, 5'd13},
        {2'b11, 12'h800, 5'd17},
        {2'b01, 12'h00F, 5'd7},
        {2'b00, 12'hFFF, 5'd7},
        {2'b11, 12'h001, 5'd17}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        ser_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        since_load++;
        if (tracking && ((wclk_out ^ inv_b) == 1'b1)) begin
            meas = since_load;
            tracking = 1'b0;
        end
    endtask

    task automatic send_slot(input logic [1:0] m, input logic [11:0] d);
        logic [13:0] f;
        f = {m, d};
        for (int i = 13; i >= 0; i--) send_bit(f[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(word_out == 12'h000, "R10 word", word_out, 0);
        chk(wclk_out == 1'b1, "R10 wclk", wclk_out, 1);
        chk(word_oe && wclk_oe, "R10 oe", {word_oe, wclk_oe}, 2'b11);

        // R1: idle enables advance nothing, word moves only on the 14th enable
        repeat (20) begin
            @(negedge clk);
            ser_in = ~ser_in;
        end
        begin
            logic [13:0] f;
            f = {2'b10, 12'h9C3};
            for (int i = 13; i >= 1; i--) send_bit(f[i]);
            chk(word_out == 12'h000, "R1 early", word_out, 0);
            send_bit(f[0]);
            chk(word_out == 12'h9C3, "R1 load", word_out, 12'h9C3);
        end
        send_slot(2'b01, 12'h000);
        send_slot(2'b01, 12'h000);

        // vector walk: R1..R5
        for (int i = 0; i < 6; i++) begin
            pw_sel = VEC[i][18:17];
            inv_b  = (VEC[i][18:17] == 2'b01);
            send_slot(2'b10, VEC[i][16:5]);
            chk(word_out == VEC[i][16:5], "R1 word", word_out, VEC[i][16:5]);
            chk(wclk_out == inv_b, inv_b ? "R4 rise with data" : "R2 fall with data", wclk_out, inv_b);
            since_load = 0;
            meas = -1;
            tracking = 1'b1;
            send_slot(2'b01, 12'hFFF);
            send_slot(2'b01, 12'h000);
            chk(meas == int'(VEC[i][4:0]), inv_b ? "R4 length" : "R3 length", meas, VEC[i][4:0]);
            chk(word_out == VEC[i][16:5], "R5 idle keeps word", word_out, VEC[i][16:5]);
            chk(wclk_out == !inv_b, "R5 idle no pulse", wclk_out, !inv_b);
        end

        // R6: invalid marker dropped, next data slot still decoded
        pw_sel = 2'b00;
        inv_b  = 1'b0;
        send_slot(2'b11, 12'hFFF);
        chk(word_out == 12'h001, "R6 dropped", word_out, 12'h001);
        chk(wclk_out == 1'b1, "R6 no pulse", wclk_out, 1);
        send_slot(2'b10, 12'h5A5);
        chk(word_out == 12'h5A5, "R6 relock", word_out, 12'h5A5);
        send_slot(2'b01, 12'h000);

        // R7: back-to-back words under the longest setting
        pw_sel = 2'b11;
        send_slot(2'b10, 12'h123);
        chk(word_out == 12'h123 && wclk_out == 1'b0, "R7 first", {wclk_out, word_out}, {1'b0, 12'h123});
        send_slot(2'b10, 12'h456);
        chk(wclk_out == 1'b1, "R7 release", wclk_out, 1);
        chk(word_out == 12'h123, "R7 old word", word_out, 12'h123);
        @(negedge clk);
        chk(word_out == 12'h456, "R7 new word", word_out, 12'h456);
        chk(wclk_out == 1'b0, "R7 new fall", wclk_out, 0);

        // R9: transmit direction
        @(negedge clk);
        rx_sel = 1'b0;
        send_slot(2'b10, 12'h777);
        chk(word_out == 12'h456, "R9 hold", word_out, 12'h456);
        chk(wclk_out == 1'b1, "R9 released", wclk_out, 1);
        rx_sel = 1'b1;
        pw_sel = 2'b00;
        send_slot(2'b10, 12'h0AB);
        chk(word_out == 12'h0AB, "R9 resume", word_out, 12'h0AB);
        send_slot(2'b01, 12'h000);

        // R8: power-down
        @(negedge clk);
        mode_sel = 2'b00;
        @(negedge clk);
        chk(!word_oe && !wclk_oe, "R8 tri-state", {word_oe, wclk_oe}, 0);
        chk(word_out == 12'h000, "R8 cleared", word_out, 0);
        repeat (4) @(negedge clk);
        mode_sel = 2'b11;
        @(negedge clk);
        chk(word_oe && wclk_oe, "R8 enables back", {word_oe, wclk_oe}, 2'b11);
        chk(wclk_out == 1'b1 && word_out == 12'h000, "R8 state after", {wclk_out, word_out}, {1'b1, 12'h000});
        send_slot(2'b10, 12'h321);
        chk(word_out == 12'h321, "R8 restart", word_out, 12'h321);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule